// File: doc/BRIEF.md
# I2C Bridge Transaction Address Filter

This block sits at the decision point of an I2C control channel that is bridged across a serial link. For each transaction it receives the 7-bit target address, the read/write bit and whether the access came from the master on this side or from a master across the link. From these and a small set of configuration inputs it chooses one of four actions: serve the access from this device's own registers, forward it over the bridge, block it, or ignore it. The verdict comes out registered, with a one-cycle valid strobe.

Two forwarding policies are selectable. In the open policy, every address other than this device's own ID is forwarded, and the address is replaced by a programmable remap value. In the restricted policy, only the remote bridge ID and the remote target ID are forwarded, each with its address unchanged. A write lock rejects writes that a far-side master aims at this device's registers. It leaves reads alone, and it leaves forwarded traffic alone. The block also holds a sticky flag for errors on the forward control channel, with a clear input.

Top module: `i2c_xfer_filter`

## Requirements
- R1: An address equal to the local ID gives action LOCAL (code 1) with the address unchanged, ahead of every forwarding rule, even when pass-all is set or the local ID equals a known remote ID.
- R2: With pass-all = 1, an address that differs from the local ID gives action FORWARD (code 2), and the output address equals the remap address.
- R3: With pass-all = 0, an address that differs from the local ID but equals the bridge ID or the target ID gives FORWARD with the address unchanged.
- R4: With pass-all = 0, an address that matches none of the three IDs gives action IGNORE (code 0).
- R5: With the write lock = 1, a write (rnw = 0) from a remote master (remote = 1) to the local ID gives action BLOCK (code 3).
- R6: A remote read to the local ID always gives LOCAL. A remote write to the local ID gives LOCAL when the write lock is 0.
- R7: The write lock has no effect on remote accesses that are forwarded under R2 or R3.
- R8: dec_valid_o is high for exactly the cycle after each cycle in which req_valid_i is high, and low otherwise. The action and address are sampled from the inputs of the strobe cycle.
- R9: A pulse on seq_err_i sets seq_err_o from the next cycle, and the flag stays set until it is cleared.
- R10: seq_clr_i = 1 clears the flag on the next cycle. When seq_err_i and seq_clr_i are both high in the same cycle, the flag is set.
- R11: After reset, dec_valid_o = 0, dec_act_o = 0, dec_addr_o = 0 and seq_err_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Address strobe for one transaction |
| req_addr_i | input | 7 | Target address of the transaction |
| req_rnw_i | input | 1 | 1 = read, 0 = write |
| req_remote_i | input | 1 | 1 = access from the far-side master |
| cfg_pass_all_i | input | 1 | 1 = forward every non-local address with remap |
| cfg_local_id_i | input | 7 | This device's own ID |
| cfg_bridge_id_i | input | 7 | Remote bridge ID |
| cfg_target_id_i | input | 7 | Remote target ID |
| cfg_remap_id_i | input | 7 | Address used for forwarding in the open policy |
| cfg_wr_lock_i | input | 1 | Reject remote writes to local registers |
| seq_err_i | input | 1 | Forward-channel sequence error pulse |
| seq_clr_i | input | 1 | Clear request for the error flag |
| dec_valid_o | output | 1 | Decision strobe |
| dec_act_o | output | 2 | Action: 0 ignore, 1 local, 2 forward, 3 block |
| dec_addr_o | output | 7 | Address to use for the action |
| seq_err_o | output | 1 | Sticky sequence-error flag |

## Verification
Two pairs of events can fall in the same cycle: a set and a clear of the error flag, and a local-ID match together with a forwarding rule that would also apply. The bench drives seq_err_i and seq_clr_i high together, both in a directed step and many times in a random phase. It also programs the local ID equal to the bridge ID, sets pass-all, and sends addresses equal to the local ID. A behavioural model decides set-wins and local-first priority on its own, and the bench compares it with the outputs on every clock.

// File: rtl/i2c_filt_pkg.sv
package i2c_filt_pkg;
  localparam int ACT_W = 2;
  typedef enum logic [ACT_W-1:0] {
    ACT_IGNORE  = 2'd0,
    ACT_LOCAL   = 2'd1,
    ACT_FORWARD = 2'd2,
    ACT_BLOCK   = 2'd3
  } act_e;
endpackage

// File: rtl/i2c_id_cmp.sv
module i2c_id_cmp #(
  parameter int ADDR_W = 7,
  parameter int N_ID   = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] id_i [N_ID],
  output logic [N_ID-1:0]   hit_o
);
  for (genvar g = 0; g < N_ID; g++) begin : g_cmp
    assign hit_o[g] = (addr_i == id_i[g]);
  end
endmodule

// File: rtl/i2c_route_decide.sv
module i2c_route_decide
  import i2c_filt_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              hit_local_i,
  input  logic              hit_known_i,
  input  logic              rnw_i,
  input  logic              remote_i,
  input  logic              pass_all_i,
  input  logic              wr_lock_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] remap_i,
  output act_e              act_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    act_o  = ACT_IGNORE;
    addr_o = addr_i;
    if (hit_local_i) begin
      // local ID wins over every forwarding rule
      act_o = (remote_i && !rnw_i && wr_lock_i) ? ACT_BLOCK : ACT_LOCAL;
    end else if (pass_all_i) begin
      act_o  = ACT_FORWARD;
      addr_o = remap_i;
    end else if (hit_known_i) begin
      act_o = ACT_FORWARD;
    end
  end
endmodule

// File: rtl/i2c_sticky_flag.sv
module i2c_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // set beats clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_xfer_filter.sv
module i2c_xfer_filter
  import i2c_filt_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_rnw_i,
  input  logic              req_remote_i,
  input  logic              cfg_pass_all_i,
  input  logic [ADDR_W-1:0] cfg_local_id_i,
  input  logic [ADDR_W-1:0] cfg_bridge_id_i,
  input  logic [ADDR_W-1:0] cfg_target_id_i,
  input  logic [ADDR_W-1:0] cfg_remap_id_i,
  input  logic              cfg_wr_lock_i,
  input  logic              seq_err_i,
  input  logic              seq_clr_i,
  output logic              dec_valid_o,
  output logic [ACT_W-1:0]  dec_act_o,
  output logic [ADDR_W-1:0] dec_addr_o,
  output logic              seq_err_o
);
  localparam int N_ID    = 3;
  localparam int IDX_LOC = 0;

  logic [ADDR_W-1:0] id_tab [N_ID];
  logic [N_ID-1:0]   hit;
  act_e              act_d;
  logic [ADDR_W-1:0] addr_d;

  assign id_tab[0] = cfg_local_id_i;
  assign id_tab[1] = cfg_bridge_id_i;
  assign id_tab[2] = cfg_target_id_i;

  i2c_id_cmp #(.ADDR_W(ADDR_W), .N_ID(N_ID)) u_cmp (
    .addr_i (req_addr_i),
    .id_i   (id_tab),
    .hit_o  (hit)
  );

  i2c_route_decide #(.ADDR_W(ADDR_W)) u_dec (
    .hit_local_i (hit[IDX_LOC]),
    .hit_known_i (|hit[N_ID-1:IDX_LOC+1]),
    .rnw_i       (req_rnw_i),
    .remote_i    (req_remote_i),
    .pass_all_i  (cfg_pass_all_i),
    .wr_lock_i   (cfg_wr_lock_i),
    .addr_i      (req_addr_i),
    .remap_i     (cfg_remap_id_i),
    .act_o       (act_d),
    .addr_o      (addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      dec_act_o   <= ACT_IGNORE;
      dec_addr_o  <= '0;
    end else begin
      dec_valid_o <= req_valid_i;
      if (req_valid_i) begin
        dec_act_o  <= act_d;
        dec_addr_o <= addr_d;
      end
    end
  end

  i2c_sticky_flag u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (seq_err_i),
    .clr_i  (seq_clr_i),
    .flag_o (seq_err_o)
  );
endmodule

// File: rtl/i2c_xfer_filter_chk.sv
module i2c_xfer_filter_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_rnw_i,
  input logic              req_remote_i,
  input logic              cfg_pass_all_i,
  input logic [ADDR_W-1:0] cfg_local_id_i,
  input logic [ADDR_W-1:0] cfg_remap_id_i,
  input logic              cfg_wr_lock_i,
  input logic              seq_err_i,
  input logic              seq_clr_i,
  input logic              dec_valid_o,
  input logic [1:0]        dec_act_o,
  input logic [ADDR_W-1:0] dec_addr_o,
  input logic              seq_err_o
);
  a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> dec_valid_o);
  a_r8_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !dec_valid_o);
  a_r1_local_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i == cfg_local_id_i && !req_remote_i) |=> dec_act_o == 2'd1);
  a_r2_remap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cfg_pass_all_i && req_addr_i != cfg_local_id_i)
      |=> (dec_act_o == 2'd2 && dec_addr_o == $past(cfg_remap_id_i)));
  a_r5_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_remote_i && !req_rnw_i && cfg_wr_lock_i && req_addr_i == cfg_local_id_i)
      |=> dec_act_o == 2'd3);
  a_r6_read_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_rnw_i && req_addr_i == cfg_local_id_i) |=> dec_act_o == 2'd1);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_err_o && !seq_clr_i) |=> seq_err_o);
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_i |=> seq_err_o);
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_clr_i && !seq_err_i) |=> !seq_err_o);
endmodule

bind i2c_xfer_filter i2c_xfer_filter_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/i2c_xfer_filter_test.sv
module i2c_xfer_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, rnw = 0, remote = 0, pass_all = 0, wr_lock = 0;
  logic seq_err = 0, seq_clr = 0;
  logic [AW-1:0] addr = 0, local_id = 7'h3a, bridge_id = 7'h18, target_id = 7'h50, remap_id = 7'h66;
  logic dec_valid, err_flag;
  logic [1:0] dec_act;
  logic [AW-1:0] dec_addr;

  int checks = 0, errors = 0;
  logic          m_valid = 0, m_err = 0;
  logic [1:0]    m_act = 0;
  logic [AW-1:0] m_addr = 0;
  string         m_tag = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_xfer_filter #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(addr),
    .req_rnw_i(rnw), .req_remote_i(remote), .cfg_pass_all_i(pass_all),
    .cfg_local_id_i(local_id), .cfg_bridge_id_i(bridge_id), .cfg_target_id_i(target_id),
    .cfg_remap_id_i(remap_id), .cfg_wr_lock_i(wr_lock), .seq_err_i(seq_err),
    .seq_clr_i(seq_clr), .dec_valid_o(dec_valid), .dec_act_o(dec_act),
    .dec_addr_o(dec_addr), .seq_err_o(err_flag)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference model: evaluate inputs present before the edge
  always @(posedge clk) if (rst_n) begin
    m_valid <= req_valid;
    if (seq_err) m_err <= 1'b1;
    else if (seq_clr) m_err <= 1'b0;
    if (req_valid) begin
      if (addr == local_id) begin
        if (remote && !rnw && wr_lock) begin m_act <= 3; m_tag <= "R5"; end
        else begin m_act <= 1; m_tag <= remote ? "R6" : "R1"; end
        m_addr <= addr;
      end else if (pass_all) begin
        m_act <= 2; m_addr <= remap_id; m_tag <= remote ? "R7" : "R2";
      end else if (addr == bridge_id || addr == target_id) begin
        m_act <= 2; m_addr <= addr; m_tag <= remote ? "R7" : "R3";
      end else begin
        m_act <= 0; m_addr <= addr; m_tag <= "R4";
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    check("R8", "valid", dec_valid, m_valid);
    check(seq_err ? "R10" : "R9", "err flag", err_flag, m_err);
    if (dec_valid) begin
      check(m_tag, "act", dec_act, m_act);
      check(m_tag, "addr", dec_addr, m_addr);
    end
  end

  task automatic send(logic [AW-1:0] a, logic r, logic rem);
    addr = a; rnw = r; remote = rem; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "valid", dec_valid, 0);
    check("R11", "act", dec_act, 0);
    check("R11", "addr", dec_addr, 0);
    check("R11", "err", err_flag, 0);
    rst_n = 1;
    @(negedge clk);
    // restricted policy
    send(local_id, 0, 0);   // R1
    send(bridge_id, 1, 0);  // R3
    send(target_id, 0, 0);  // R3
    send(7'h11, 0, 0);      // R4
    send(local_id, 0, 1);   // R6 unlocked write
    wr_lock = 1;
    send(local_id, 0, 1);   // R5
    send(local_id, 1, 1);   // R6 read under lock
    send(target_id, 0, 1);  // R7
    // open policy
    pass_all = 1;
    send(7'h11, 0, 1);      // R2/R7
    send(local_id, 1, 0);   // R1 priority
    // local ID equal to bridge ID
    pass_all = 0; bridge_id = local_id;
    send(local_id, 0, 0);   // R1
    bridge_id = 7'h18;
    // error flag
    seq_err = 1; @(negedge clk); seq_err = 0;
    repeat (3) @(negedge clk);                  // R9 stays
    seq_err = 1; seq_clr = 1; @(negedge clk);   // R10 set wins
    seq_err = 0; @(negedge clk);                // R10 clear
    seq_clr = 0; @(negedge clk);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 5));
      case (pick)
        0: addr = local_id;
        1: addr = bridge_id;
        2: addr = target_id;
        3: addr = remap_id;
        default: addr = 7'($urandom);
      endcase
      req_valid = 1'($urandom);
      rnw = 1'($urandom); remote = 1'($urandom);
      pass_all = 1'($urandom); wr_lock = 1'($urandom);
      seq_err = ($urandom_range(0, 7) == 0);
      seq_clr = ($urandom_range(0, 5) == 0);
      if (i % 500 == 0) remap_id = 7'($urandom);
      @(negedge clk);
    end
    req_valid = 0; seq_err = 0; seq_clr = 0;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule